// File: doc/BRIEF.md
# Coprocessor Control Register Bank

This block is the host-facing bank of control and status registers for a coprocessor. A host reaches it through a byte-wide port with an 8-bit offset. Only offsets 0x40 to 0xFF are decoded. The bank holds the following state:
- the DMA descriptor (source, target and length);
- the program base and page;
- the start counter;
- the wait-state setting;
- the cache lock and preload bits;
- interrupt control;
- a 32-byte vector table;
- sixteen 24-bit general registers. The host reaches each of these one byte lane at a time.

Several writes have side effects, and most of those side effects depend on whether the core is halted. They are:
- starting a DMA;
- launching the program at a computed pc;
- halting the core;
- a timed suspend, whose length is encoded in the offset that was written;
- clearing or masking the pending interrupt.

A two-state machine tracks the core. In the HALT state the core is stopped. The transition named *launch* (a write to 0x4F) leads to RUN. The transition named *stop* (a write to 0x53, or `core_stop` from the core) leads back to HALT. Reset enters HALT. The suspend flag is kept apart from this machine. Each side-effect pulse lasts exactly one clock cycle. Host reads are combinational from the current offset.

Top module: `cpctl_regs`

## Requirements
- R1: Offsets 0x40-0x42 (DMA source), 0x43-0x44 (length) and 0x45-0x47 (target) are little-endian and read back as written. A write to 0x47 while halted raises `dma_active` and pulses `dma_start`. The same write while running gives no pulse. `dma_done` clears `dma_active`.
- R2: Offsets 0x49-0x4B hold the 24-bit program base, little-endian. Offset 0x4D is the page low byte. Offset 0x4E keeps only bits 6:0 of the written byte and reads back with bit 7 clear.
- R3: A write to 0x4F stores the counter byte. If the core is halted, the same write sets `pc` = page*256 + byte, moves the machine to RUN and pulses `start`.
- R4: Offset 0x50 holds the ROM wait count in bits 6:4 and the RAM wait count in bits 2:0. Every other bit reads back as 0. Offset 0x4C (lock bits 1:0) changes only while halted. A write to 0x48 while halted stores bit 0 as `cache_preload` and pulses `cache_load`. While running, the same write does neither.
- R5: `irq` equals pending AND NOT disable. `irq_raise` sets pending. Writing 0x51 with bit 0 set sets disable and clears pending. Writing it with bit 0 clear clears disable, so a pending interrupt shows again. A write to 0x5E clears pending.
- R6: A write to any offset from 0x55 to 0x5C sets `suspend`, with `suspend_cycles` = 32*(offset-0x55). A write to 0x5D clears `suspend`.
- R7: Reads of 0x53-0x57, 0x59 and 0x5B-0x5F return the status byte. Bit 7 is `bus_access`. Bit 6 is busy, which is high when running or when `dma_active` is set. Bit 1 is the pending interrupt and bit 0 is `suspend`. The other bits are 0.
- R8: Offsets 0x60-0x7F are a 32-byte vector table that reads back what was written.
- R9: Offsets 0x80-0xAF and 0xC0-0xEF both map to the general registers. The index is (offset AND 0x3F)/3, and the lane is the remainder (lane 0 is bits 7:0). Writes take effect only while halted or suspended.
- R10: While running and not suspended, a general-register read returns byte lane (offset AND 0x3F) mod 3 of `core_mdr`.
- R11: Offsets 0x00-0x3F, 0x58, 0x5A, 0xB0-0xBF and 0xF0-0xFF read as 0x00.
- R12: A write to 0x53, or `core_stop`, moves RUN to HALT and pulses `halt_pulse`. A write to 0x53 while already halted gives no pulse.
- R13: After reset the core is halted and every register reads 0. Every pulse output (`dma_start`, `start`, `halt_pulse`, `cache_load`) is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_addr | input | 8 | Register offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte for `host_addr` (combinational) |
| core_mdr | input | 24 | Core memory-data register |
| core_stop | input | 1 | Core requests halt |
| dma_done | input | 1 | Clears the DMA-active flag |
| irq_raise | input | 1 | Core sets the pending interrupt |
| bus_access | input | 1 | Core owns the cartridge bus (status bit 7) |
| pc | output | 23 | Start address latched at launch |
| halted | output | 1 | Machine is in HALT |
| dma_start | output | 1 | One-cycle DMA start pulse |
| dma_active | output | 1 | DMA in progress |
| start | output | 1 | One-cycle program start pulse |
| halt_pulse | output | 1 | One-cycle pulse on entry to HALT |
| cache_load | output | 1 | One-cycle cache preload request |
| cache_preload | output | 1 | Stored preload bit |
| suspend | output | 1 | Suspend flag |
| suspend_cycles | output | 8 | Suspend duration in cycles |
| irq | output | 1 | Interrupt to the host |

## Verification
The assertions assume that `host_wr` is a single-cycle strobe per byte and that `host_addr` and `host_wdata` are stable while it is high. They also assume that `irq_raise` and `dma_done` never arrive in the same cycle as a host write that would clear the same flag. The bench drives every input on the falling edge and separates host writes by an idle cycle. It raises `irq_raise`, `dma_done` and `core_stop` only when no host write is active, so it never creates same-cycle conflicts.

// File: rtl/cpctl_pkg.sv
package cpctl_pkg;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    localparam logic [7:0] OFF_DMA_GO   = 8'h47;
    localparam logic [7:0] OFF_PRELOAD  = 8'h48;
    localparam logic [7:0] OFF_LOCK     = 8'h4C;
    localparam logic [7:0] OFF_LAUNCH   = 8'h4F;
    localparam logic [7:0] OFF_WAITS    = 8'h50;
    localparam logic [7:0] OFF_IRQ_CTL  = 8'h51;
    localparam logic [7:0] OFF_HALT     = 8'h53;
    localparam logic [7:0] OFF_SUSP_LO  = 8'h55;
    localparam logic [7:0] OFF_SUSP_HI  = 8'h5C;
    localparam logic [7:0] OFF_RESUME   = 8'h5D;
    localparam logic [7:0] OFF_IRQ_ACK  = 8'h5E;

    localparam int SUSP_SHIFT = 5;

endpackage

// File: rtl/cpctl_gpr.sv
module cpctl_gpr #(
    parameter int COUNT  = 16,
    parameter int WORD_W = 24,
    parameter int LANE_W = 8,
    localparam int IDX_W = $clog2(COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        lane,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    logic [WORD_W-1:0]       words [COUNT];
    logic [COUNT*WORD_W-1:0] flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < COUNT; i++) words[i] <= '0;
        end else if (we) begin
            words[idx][LANE_W*int'(lane) +: LANE_W] <= wdata;
        end
    end

    always_comb begin
        rdata = words[idx][LANE_W*int'(lane) +: LANE_W];
    end

    always_comb begin
        for (int i = 0; i < COUNT; i++) flat[i*WORD_W +: WORD_W] = words[i];
    end

    AST_GPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flat)); // R9

endmodule

// File: rtl/cpctl_vec.sv
module cpctl_vec #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

    AST_VEC_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(idx)] == $past(wdata))); // R8

endmodule

// File: rtl/cpctl_regs.sv
module cpctl_regs
    import cpctl_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int GPR_COUNT = 16,
    parameter int VEC_DEPTH = 32,
    parameter int PAGE_W    = 15,
    parameter int WAIT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [7:0]          host_addr,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          host_rdata,
    input  logic [WORD_W-1:0]   core_mdr,
    input  logic                core_stop,
    input  logic                dma_done,
    input  logic                irq_raise,
    input  logic                bus_access,
    output logic [PAGE_W+7:0]   pc,
    output logic                halted,
    output logic                dma_start,
    output logic                dma_active,
    output logic                start,
    output logic                halt_pulse,
    output logic                cache_load,
    output logic                cache_preload,
    output logic                suspend,
    output logic [7:0]          suspend_cycles,
    output logic                irq
);

    localparam int LANES    = WORD_W / 8;
    localparam int GPR_SPAN = GPR_COUNT * LANES;
    localparam int GIDX_W   = $clog2(GPR_COUNT);
    localparam int VIDX_W   = $clog2(VEC_DEPTH);
    localparam int PC_W     = PAGE_W + 8;

    run_state_t state, state_nx;

    logic [23:0]       dma_src, dma_dst, prog_base;
    logic [15:0]       dma_len;
    logic [PAGE_W-1:0] page;
    logic [7:0]        counter;
    logic [1:0]        lock;
    logic [WAIT_W-1:0] rom_wait, ram_wait;
    logic              irq_dis, irq_pend, spare_bit;

    logic              is_halted;
    logic [5:0]        lo6, gpr_q, gpr_r;
    logic              in_gpr, in_vec;
    logic [GIDX_W-1:0] gpr_idx;
    logic [1:0]        gpr_lane;
    logic              gpr_we, vec_we;
    logic [7:0]        gpr_rdata, vec_rdata, mdr_lane, status_byte;
    logic              wr_launch, wr_halt, wr_dma_go, wr_preload, wr_susp;
    logic [2:0]        susp_k;

    assign is_halted = (state == ST_HALT);
    assign halted    = is_halted;

    // ---------------- decode ----------------
    assign lo6      = host_addr[5:0];
    assign in_gpr   = host_addr[7] && (int'(lo6) < GPR_SPAN);
    assign in_vec   = (host_addr[7:5] == 3'b011);
    assign gpr_q    = lo6 / 6'(LANES);
    assign gpr_r    = lo6 % 6'(LANES);
    assign gpr_idx  = gpr_q[GIDX_W-1:0];
    assign gpr_lane = gpr_r[1:0];
    assign mdr_lane = core_mdr[8*int'(gpr_lane) +: 8];

    assign wr_launch  = host_wr && (host_addr == OFF_LAUNCH);
    assign wr_halt    = host_wr && (host_addr == OFF_HALT);
    assign wr_dma_go  = host_wr && (host_addr == OFF_DMA_GO);
    assign wr_preload = host_wr && (host_addr == OFF_PRELOAD);
    assign wr_susp    = host_wr && (host_addr >= OFF_SUSP_LO) && (host_addr <= OFF_SUSP_HI);
    assign susp_k     = 3'(host_addr - OFF_SUSP_LO);

    assign gpr_we = host_wr && in_gpr && (is_halted || suspend);
    assign vec_we = host_wr && in_vec;

    // ---------------- storage sub-blocks ----------------
    cpctl_gpr #(.COUNT(GPR_COUNT), .WORD_W(WORD_W), .LANE_W(8)) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .idx   (gpr_idx),
        .lane  (gpr_lane),
        .wdata (host_wdata),
        .rdata (gpr_rdata)
    );

    cpctl_vec #(.DEPTH(VEC_DEPTH), .DATA_W(8)) u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vec_we),
        .idx   (host_addr[VIDX_W-1:0]),
        .wdata (host_wdata),
        .rdata (vec_rdata)
    );

    // ---------------- run state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (wr_launch)             state_nx = ST_RUN;
            ST_RUN:  if (wr_halt || core_stop)  state_nx = ST_HALT;
            default:                            state_nx = ST_HALT;
        endcase
    end

    // one-cycle side-effect pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start      <= 1'b0;
            halt_pulse <= 1'b0;
            dma_start  <= 1'b0;
            cache_load <= 1'b0;
        end else begin
            start      <= is_halted && wr_launch;
            halt_pulse <= (state == ST_RUN) && (state_nx == ST_HALT);
            dma_start  <= is_halted && wr_dma_go;
            cache_load <= is_halted && wr_preload;
        end
    end

    // ---------------- register writes ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_src        <= '0;
            dma_len        <= '0;
            dma_dst        <= '0;
            dma_active     <= 1'b0;
            prog_base      <= '0;
            page           <= '0;
            counter        <= '0;
            pc             <= '0;
            lock           <= '0;
            cache_preload  <= 1'b0;
            rom_wait       <= '0;
            ram_wait       <= '0;
            irq_dis        <= 1'b0;
            irq_pend       <= 1'b0;
            spare_bit      <= 1'b0;
            suspend        <= 1'b0;
            suspend_cycles <= '0;
        end else begin
            if (dma_done)  dma_active <= 1'b0;
            if (irq_raise) irq_pend   <= 1'b1;
            if (wr_susp) begin
                suspend        <= 1'b1;
                suspend_cycles <= {susp_k, {SUSP_SHIFT{1'b0}}};
            end
            if (host_wr) begin
                case (host_addr)
                    8'h40: dma_src[7:0]    <= host_wdata;
                    8'h41: dma_src[15:8]   <= host_wdata;
                    8'h42: dma_src[23:16]  <= host_wdata;
                    8'h43: dma_len[7:0]    <= host_wdata;
                    8'h44: dma_len[15:8]   <= host_wdata;
                    8'h45: dma_dst[7:0]    <= host_wdata;
                    8'h46: dma_dst[15:8]   <= host_wdata;
                    8'h47: begin
                        dma_dst[23:16] <= host_wdata;
                        if (is_halted) dma_active <= 1'b1;
                    end
                    8'h48: if (is_halted) cache_preload <= host_wdata[0];
                    8'h49: prog_base[7:0]   <= host_wdata;
                    8'h4A: prog_base[15:8]  <= host_wdata;
                    8'h4B: prog_base[23:16] <= host_wdata;
                    8'h4C: if (is_halted) lock <= host_wdata[1:0];
                    8'h4D: page[7:0]        <= host_wdata;
                    8'h4E: page[PAGE_W-1:8] <= host_wdata[PAGE_W-9:0];
                    8'h4F: begin
                        counter <= host_wdata;
                        if (is_halted) pc <= PC_W'({page, host_wdata});
                    end
                    8'h50: begin
                        rom_wait <= host_wdata[4 +: WAIT_W];
                        ram_wait <= host_wdata[0 +: WAIT_W];
                    end
                    8'h51: begin
                        irq_dis <= host_wdata[0];
                        if (host_wdata[0]) irq_pend <= 1'b0;
                    end
                    8'h52: spare_bit <= host_wdata[0];
                    8'h5D: suspend   <= 1'b0;
                    8'h5E: irq_pend  <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assign irq = irq_pend && !irq_dis;

    // ---------------- read mux ----------------
    assign status_byte = {bus_access, (!is_halted || dma_active), 4'b0000, irq_pend, suspend};

    always_comb begin
        host_rdata = 8'h00;
        if (in_gpr) begin
            host_rdata = (is_halted || suspend) ? gpr_rdata : mdr_lane;
        end else if (in_vec) begin
            host_rdata = vec_rdata;
        end else begin
            case (host_addr)
                8'h40: host_rdata = dma_src[7:0];
                8'h41: host_rdata = dma_src[15:8];
                8'h42: host_rdata = dma_src[23:16];
                8'h43: host_rdata = dma_len[7:0];
                8'h44: host_rdata = dma_len[15:8];
                8'h45: host_rdata = dma_dst[7:0];
                8'h46: host_rdata = dma_dst[15:8];
                8'h47: host_rdata = dma_dst[23:16];
                8'h48: host_rdata = {7'b0, cache_preload};
                8'h49: host_rdata = prog_base[7:0];
                8'h4A: host_rdata = prog_base[15:8];
                8'h4B: host_rdata = prog_base[23:16];
                8'h4C: host_rdata = {6'b0, lock};
                8'h4D: host_rdata = page[7:0];
                8'h4E: host_rdata = 8'(page[PAGE_W-1:8]);
                8'h4F: host_rdata = counter;
                8'h50: host_rdata = {1'b0, rom_wait, 1'b0, ram_wait};
                8'h51: host_rdata = {7'b0, irq_dis};
                8'h52: host_rdata = {7'b0, spare_bit};
                8'h53, 8'h54, 8'h55, 8'h56, 8'h57, 8'h59,
                8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F: host_rdata = status_byte;
                default: host_rdata = 8'h00;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_DMA_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma_go && is_halted) |=> (dma_start && dma_active)); // R1

    AST_DMA_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma_go && !is_halted) |=> !dma_start); // R1

    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_launch && is_halted) |=> (start && !halted && pc == PC_W'({$past(page), $past(host_wdata)}))); // R3

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFF_IRQ_CTL && host_wdata[0]) |=> !irq); // R5

    AST_SUSPEND_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_susp |=> (suspend && suspend_cycles == 8'(($past(host_addr) - OFF_SUSP_LO) * 32))); // R6

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |-> (halted && !$past(halted))); // R12

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R13

endmodule

// File: tb/cpctl_regs_test.sv
module cpctl_regs_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [23:0] core_mdr = 24'h0;
    logic        core_stop = 1'b0;
    logic        dma_done = 1'b0;
    logic        irq_raise = 1'b0;
    logic        bus_access = 1'b0;
    logic [22:0] pc;
    logic        halted, dma_start, dma_active, start, halt_pulse;
    logic        cache_load, cache_preload, suspend, irq;
    logic [7:0]  suspend_cycles;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic s_dma, s_start, s_halt, s_cl;
    logic [7:0] rv;

    always #(CLK_P/2) clk = ~clk;

    cpctl_regs uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .core_mdr(core_mdr),
        .core_stop(core_stop), .dma_done(dma_done), .irq_raise(irq_raise),
        .bus_access(bus_access), .pc(pc), .halted(halted), .dma_start(dma_start),
        .dma_active(dma_active), .start(start), .halt_pulse(halt_pulse),
        .cache_load(cache_load), .cache_preload(cache_preload), .suspend(suspend),
        .suspend_cycles(suspend_cycles), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        s_dma = dma_start; s_start = start; s_halt = halt_pulse; s_cl = cache_load;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk($sformatf("%s off=0x%0h", tag, a), int'(d), int'(exp));
    endtask

    task automatic pulse_quiet(input string tag);
        @(negedge clk);
        chk({tag, " pulses low next cycle"},
            int'({dma_start, start, halt_pulse, cache_load}), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13: reset state
        chk("R13 halted after reset", int'(halted), 1);
        chk("R13 outputs after reset",
            int'({irq, suspend, dma_active, start, dma_start, halt_pulse, cache_load}), 0);
        chk("R13 pc after reset", int'(pc), 0);
        for (int a = 0; a < 256; a++) rdchk("R13 reset read", 8'(a), 8'h00);

        // R1: DMA descriptor and start
        for (int i = 0; i < 8; i++) wr(8'(8'h40 + i), 8'(8'h11 * (i + 1)));
        chk("R1 dma_start pulse", int'(s_dma), 1);
        chk("R1 dma_active set", int'(dma_active), 1);
        pulse_quiet("R13 dma");
        for (int i = 0; i < 8; i++) rdchk("R1 dma readback", 8'(8'h40 + i), 8'(8'h11 * (i + 1)));
        rdchk("R7 busy from dma", 8'h53, 8'h40);
        @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
        chk("R1 dma_done clears", int'(dma_active), 0);

        // R2: program base and page
        wr(8'h49, 8'hA5); wr(8'h4A, 8'h5A); wr(8'h4B, 8'hC3);
        rdchk("R2 base0", 8'h49, 8'hA5);
        rdchk("R2 base1", 8'h4A, 8'h5A);
        rdchk("R2 base2", 8'h4B, 8'hC3);
        wr(8'h4D, 8'h34); wr(8'h4E, 8'h92);
        rdchk("R2 page low", 8'h4D, 8'h34);
        rdchk("R2 page high masked", 8'h4E, 8'h12);

        // R4: waits, locks, preload while halted
        wr(8'h50, 8'hFF);
        rdchk("R4 wait packing", 8'h50, 8'h77);
        wr(8'h50, 8'h52);
        rdchk("R4 wait packing 2", 8'h50, 8'h52);
        wr(8'h4C, 8'hFF);
        rdchk("R4 lock halted", 8'h4C, 8'h03);
        wr(8'h48, 8'h01);
        chk("R4 cache_load pulse", int'(s_cl), 1);
        chk("R4 cache_preload", int'(cache_preload), 1);
        pulse_quiet("R13 cache_load");
        rdchk("R4 preload read", 8'h48, 8'h01);

        // R8: vector table sweep
        for (int i = 0; i < 32; i++) wr(8'(8'h60 + i), 8'(i * 7 + 3));
        for (int i = 0; i < 32; i++) rdchk("R8 vector", 8'(8'h60 + i), 8'(i * 7 + 3));

        // R9: general registers, both windows, while halted
        for (int i = 0; i < 48; i++) wr(8'(8'h80 + i), 8'((8'h80 + i) ^ 8'h5A));
        for (int i = 0; i < 48; i++) begin
            rdchk("R9 window A", 8'(8'h80 + i), 8'((8'h80 + i) ^ 8'h5A));
            rdchk("R9 window B alias", 8'(8'hC0 + i), 8'((8'h80 + i) ^ 8'h5A));
        end
        for (int i = 0; i < 48; i++) wr(8'(8'hC0 + i), 8'(i * 5 + 1));
        for (int i = 0; i < 48; i++) rdchk("R9 write via B", 8'(8'h80 + i), 8'(i * 5 + 1));

        // R12: halt while halted gives no pulse
        wr(8'h53, 8'h00);
        chk("R12 no halt pulse when halted", int'(s_halt), 0);

        // R3: launch
        wr(8'h4F, 8'h56);
        chk("R3 start pulse", int'(s_start), 1);
        chk("R3 pc", int'(pc), 23'h123456);
        chk("R3 running", int'(halted), 0);
        pulse_quiet("R13 start");
        rdchk("R3 counter read", 8'h4F, 8'h56);
        rdchk("R7 busy running", 8'h5F, 8'h40);

        // running: ignored writes
        wr(8'h47, 8'h77);
        chk("R1 no dma_start while running", int'(s_dma), 0);
        chk("R1 dma_active stays low running", int'(dma_active), 0);
        wr(8'h4C, 8'h00);
        rdchk("R4 lock ignored running", 8'h4C, 8'h03);
        wr(8'h48, 8'h00);
        chk("R4 no cache_load running", int'(s_cl), 0);
        rdchk("R4 preload kept running", 8'h48, 8'h01);
        wr(8'h4D, 8'h00);
        wr(8'h4F, 8'h99);
        chk("R3 no restart while running", int'(s_start), 0);
        chk("R3 pc kept while running", int'(pc), 23'h123456);

        // R10: mdr lanes while running
        core_mdr = 24'hA1B2C3;
        rdchk("R10 lane0", 8'h83, 8'hC3);
        rdchk("R10 lane1", 8'h84, 8'hB2);
        rdchk("R10 lane2 window B", 8'hC5, 8'hA1);
        wr(8'h80, 8'hEE);

        // R6: suspend sweep
        for (int k = 0; k < 8; k++) begin
            wr(8'(8'h55 + k), 8'h00);
            chk($sformatf("R6 suspend set k=%0d", k), int'(suspend), 1);
            chk($sformatf("R6 suspend_cycles k=%0d", k), int'(suspend_cycles), 32 * k);
        end
        rdchk("R7 status suspended", 8'h57, 8'h41);
        rdchk("R9 suspended read from gpr", 8'h80, 8'h01);
        wr(8'h81, 8'h99);
        rdchk("R9 suspended write accepted", 8'h81, 8'h99);
        wr(8'h5D, 8'h00);
        chk("R6 suspend cleared", int'(suspend), 0);
        rdchk("R10 back to mdr", 8'h81, 8'hB2);

        // R12: halt by write
        wr(8'h53, 8'h00);
        chk("R12 halt pulse", int'(s_halt), 1);
        chk("R12 halted", int'(halted), 1);
        pulse_quiet("R13 halt");
        rdchk("R9 running write ignored", 8'h80, 8'h01);

        // R12: halt by core_stop
        wr(8'h4F, 8'h10);
        chk("R3 relaunch pc", int'(pc), 23'h120010);
        @(negedge clk); core_stop = 1'b1;
        @(negedge clk); core_stop = 1'b0;
        chk("R12 core_stop halt pulse", int'(halt_pulse), 1);
        chk("R12 core_stop halted", int'(halted), 1);

        // R5: interrupts
        @(negedge clk); irq_raise = 1'b1; @(negedge clk); irq_raise = 1'b0;
        chk("R5 irq raised", int'(irq), 1);
        rdchk("R7 pending bit", 8'h5E, 8'h02);
        wr(8'h5E, 8'h00);
        chk("R5 ack clears irq", int'(irq), 0);
        @(negedge clk); irq_raise = 1'b1; @(negedge clk); irq_raise = 1'b0;
        wr(8'h51, 8'h01);
        chk("R5 disable drops irq", int'(irq), 0);
        rdchk("R5 disable clears pending", 8'h5E, 8'h00);
        @(negedge clk); irq_raise = 1'b1; @(negedge clk); irq_raise = 1'b0;
        chk("R5 masked irq", int'(irq), 0);
        wr(8'h51, 8'h00);
        chk("R5 enable reasserts irq", int'(irq), 1);

        // R7: status map with bus_access
        bus_access = 1'b1;
        wr(8'h5E, 8'h00);
        begin
            logic [7:0] st_offs [11] = '{8'h53, 8'h54, 8'h55, 8'h56, 8'h57, 8'h59,
                                         8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F};
            for (int i = 0; i < 11; i++) rdchk("R7 status", st_offs[i], 8'h80);
        end

        // R11: undefined offsets
        for (int a = 0; a < 64; a++) rdchk("R11 low window", 8'(a), 8'h00);
        rdchk("R11 gap 58", 8'h58, 8'h00);
        rdchk("R11 gap 5A", 8'h5A, 8'h00);
        for (int a = 0; a < 16; a++) begin
            rdchk("R11 gap B0", 8'(8'hB0 + a), 8'h00);
            rdchk("R11 gap F0", 8'(8'hF0 + a), 8'h00);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule